// File: doc/BRIEF.md
# GPIO Bank Pin Control Registers

This block holds the per-pin control state of a 32-pin general-purpose I/O bank. A simple register bus carries an address, a write enable, write data and combinational read data. The block keeps five one-bit-per-pin registers: output level, drive direction, pull disable, and two function-select planes. From these it drives the pad ring with an output level, an output enable, a pull enable, a pull direction and a 2-bit function code for each pin. It also samples the pad levels through a two-flop synchronizer, so that software can read them.

Output level and direction each have two write-only alias addresses. One sets and one clears exactly the bits written as 1. This lets a driver change one pin without a read-modify-write that could race with another agent. The output-level bit has a second job on input pins: when the pull resistor is enabled, this bit selects pull-up or pull-down.

Top module: `gpio_pinctl_bank`

## Requirements
- R1: After reset, every pin is an input, output data is 0, pulls are enabled, the function code is 00, and reads of addresses 0x1, 0x4, 0x7, 0x8 and 0x9 return 0.
- R2: A write to address 0x2 sets every output-data bit written as 1 and leaves the bits written as 0 unchanged; the new level appears on pad_out after the write edge.
- R3: A write to address 0x3 clears every output-data bit written as 1 and leaves the bits written as 0 unchanged.
- R4: A write to 0x5 sets, and a write to 0x6 clears, the direction bits written as 1. pad_oe equals the direction word (1 = output). The direction word reads back at 0x4 and changes only on writes to 0x4, 0x5 or 0x6.
- R5: Function-select plane A (address 0x8) and plane B (address 0x9) are read/write. For pin i, pad_func[2i+1:2i] = {B[i], A[i]}, giving 00 plain I/O, 01 function A, 10 function B, 11 function C.
- R6: pad_pull_en[i] is 1 exactly when pull-disable bit i (address 0x7) is 0 and pin i is an input.
- R7: pad_pull_up equals the output-data word, so the level left in the data bit of an input pin selects pull-up (1) or pull-down (0).
- R8: A read of address 0x0 returns the pad_in level as sampled at the second rising clock edge after it is applied. After one edge the read still returns the previous level.
- R9: Addresses 0xA to 0xF, and the write-only aliases 0x2, 0x3, 0x5 and 0x6, read as 0. Writes to 0xA to 0xF change no state.
- R10: A write to 0x1 replaces the whole output-data word, and a write to 0x4 replaces the whole direction word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register word address |
| bus_we | input | 1 | Write enable, one write per cycle |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output level per pin |
| pad_oe | output | 32 | Output enable per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction, 1 = up |
| pad_func | output | 64 | Two-bit function code per pin |

## Verification
The hardest state to reach from the ports is an input pin whose pull direction comes from a data bit that was left over from an earlier output phase. The bench gets there in three steps: it drives a pin high as an output, clears its direction through the clear alias, and then checks that the pull turns on in the pull-up sense without any write to the data word. Function codes are swept so that every pin sees all four codes across four rotated patterns. The synchronizer latency is pinned by reading the input word one edge and two edges after each new pad pattern.

// File: rtl/gpio_pinctl_pkg.sv
package gpio_pinctl_pkg;

   // Word offsets of the register map
   localparam int unsigned OFF_DIN      = 0;
   localparam int unsigned OFF_DOUT     = 1;
   localparam int unsigned OFF_DOUT_SET = 2;
   localparam int unsigned OFF_DOUT_CLR = 3;
   localparam int unsigned OFF_DIR      = 4;
   localparam int unsigned OFF_DIR_SET  = 5;
   localparam int unsigned OFF_DIR_CLR  = 6;
   localparam int unsigned OFF_PULL_OFF = 7;
   localparam int unsigned OFF_FSEL_A   = 8;
   localparam int unsigned OFF_FSEL_B   = 9;
   localparam int unsigned OFF_LAST     = OFF_FSEL_B;

   localparam int unsigned FUNC_W = 2;

   // Write strobes for one register: full write, set alias, clear alias
   typedef struct packed {
      logic wr;
      logic set;
      logic clr;
   } wstb_t;

endpackage

// File: rtl/gpio_pinctl_sync.sv
module gpio_pinctl_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_pinctl_sync: STAGES must be at least 2");
   end

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= '0;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_pinctl_bitreg.sv
module gpio_pinctl_bitreg
   import gpio_pinctl_pkg::*;
#(
   parameter int unsigned  W         = 32,
   parameter logic [W-1:0] RST_VAL   = '0,
   parameter bit           HAS_ALIAS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  wstb_t        stb,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   if (HAS_ALIAS) begin : g_alias
      always_comb begin
         nxt = q;
         if (stb.wr)       nxt = wdata;
         else if (stb.set) nxt = q | wdata;
         else if (stb.clr) nxt = q & ~wdata;
      end
   end else begin : g_plain
      logic unused_alias;
      assign unused_alias = stb.set | stb.clr;
      always_comb nxt = stb.wr ? wdata : q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= nxt;
   end
endmodule

// File: rtl/gpio_pinctl_regif.sv
module gpio_pinctl_regif
   import gpio_pinctl_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [NPINS-1:0]  din,
   input  logic [NPINS-1:0]  dout,
   input  logic [NPINS-1:0]  dir,
   input  logic [NPINS-1:0]  poff,
   input  logic [NPINS-1:0]  fsel_a,
   input  logic [NPINS-1:0]  fsel_b,
   output wstb_t             dout_stb,
   output wstb_t             dir_stb,
   output wstb_t             poff_stb,
   output wstb_t             fa_stb,
   output wstb_t             fb_stb,
   output logic [NPINS-1:0]  rdata
);
   localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(OFF_DIN);
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);
   localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(OFF_DOUT_SET);
   localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(OFF_DOUT_CLR);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
   localparam logic [ADDR_W-1:0] A_RSET = ADDR_W'(OFF_DIR_SET);
   localparam logic [ADDR_W-1:0] A_RCLR = ADDR_W'(OFF_DIR_CLR);
   localparam logic [ADDR_W-1:0] A_POFF = ADDR_W'(OFF_PULL_OFF);
   localparam logic [ADDR_W-1:0] A_FA   = ADDR_W'(OFF_FSEL_A);
   localparam logic [ADDR_W-1:0] A_FB   = ADDR_W'(OFF_FSEL_B);

   always_comb begin
      dout_stb = '0;
      dir_stb  = '0;
      poff_stb = '0;
      fa_stb   = '0;
      fb_stb   = '0;
      if (bus_we) begin
         case (bus_addr)
            A_DOUT:  dout_stb.wr  = 1'b1;
            A_DSET:  dout_stb.set = 1'b1;
            A_DCLR:  dout_stb.clr = 1'b1;
            A_DIR:   dir_stb.wr   = 1'b1;
            A_RSET:  dir_stb.set  = 1'b1;
            A_RCLR:  dir_stb.clr  = 1'b1;
            A_POFF:  poff_stb.wr  = 1'b1;
            A_FA:    fa_stb.wr    = 1'b1;
            A_FB:    fb_stb.wr    = 1'b1;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (bus_addr)
         A_DIN:   rdata = din;
         A_DOUT:  rdata = dout;
         A_DIR:   rdata = dir;
         A_POFF:  rdata = poff;
         A_FA:    rdata = fsel_a;
         A_FB:    rdata = fsel_b;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_pinctl_padmap.sv
module gpio_pinctl_padmap
   import gpio_pinctl_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic [NPINS-1:0]        dout,
   input  logic [NPINS-1:0]        dir,
   input  logic [NPINS-1:0]        poff,
   input  logic [NPINS-1:0]        fsel_a,
   input  logic [NPINS-1:0]        fsel_b,
   output logic [NPINS-1:0]        pad_out,
   output logic [NPINS-1:0]        pad_oe,
   output logic [NPINS-1:0]        pad_pull_en,
   output logic [NPINS-1:0]        pad_pull_up,
   output logic [FUNC_W*NPINS-1:0] pad_func
);
   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      assign pad_out[i]                 = dout[i];
      assign pad_oe[i]                  = dir[i];
      assign pad_pull_en[i]             = ~poff[i] & ~dir[i];
      assign pad_pull_up[i]             = dout[i];
      assign pad_func[FUNC_W*i +: FUNC_W] = {fsel_b[i], fsel_a[i]};
   end
endmodule

// File: rtl/gpio_pinctl_bank.sv
module gpio_pinctl_bank
   import gpio_pinctl_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic                    bus_we,
   input  logic [NPINS-1:0]        bus_wdata,
   output logic [NPINS-1:0]        bus_rdata,
   input  logic [NPINS-1:0]        pad_in,
   output logic [NPINS-1:0]        pad_out,
   output logic [NPINS-1:0]        pad_oe,
   output logic [NPINS-1:0]        pad_pull_en,
   output logic [NPINS-1:0]        pad_pull_up,
   output logic [FUNC_W*NPINS-1:0] pad_func
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("gpio_pinctl_bank: NPINS must be 1..32");
   end
   if ((1 << ADDR_W) <= OFF_LAST) begin : g_bad_addr
      $error("gpio_pinctl_bank: ADDR_W too small for the register map");
   end

   logic [NPINS-1:0] din, dout, dir, poff, fsel_a, fsel_b;
   wstb_t dout_stb, dir_stb, poff_stb, fa_stb, fb_stb;

   gpio_pinctl_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pad_in), .q(din));

   gpio_pinctl_regif #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regif (
      .bus_addr(bus_addr), .bus_we(bus_we),
      .din(din), .dout(dout), .dir(dir), .poff(poff),
      .fsel_a(fsel_a), .fsel_b(fsel_b),
      .dout_stb(dout_stb), .dir_stb(dir_stb), .poff_stb(poff_stb),
      .fa_stb(fa_stb), .fb_stb(fb_stb), .rdata(bus_rdata));

   gpio_pinctl_bitreg #(.W(NPINS), .RST_VAL('0), .HAS_ALIAS(1'b1)) u_dout (
      .clk(clk), .rst_n(rst_n), .stb(dout_stb), .wdata(bus_wdata), .q(dout));
   gpio_pinctl_bitreg #(.W(NPINS), .RST_VAL('0), .HAS_ALIAS(1'b1)) u_dir (
      .clk(clk), .rst_n(rst_n), .stb(dir_stb), .wdata(bus_wdata), .q(dir));
   gpio_pinctl_bitreg #(.W(NPINS), .RST_VAL('0), .HAS_ALIAS(1'b0)) u_poff (
      .clk(clk), .rst_n(rst_n), .stb(poff_stb), .wdata(bus_wdata), .q(poff));
   gpio_pinctl_bitreg #(.W(NPINS), .RST_VAL('0), .HAS_ALIAS(1'b0)) u_fsel_a (
      .clk(clk), .rst_n(rst_n), .stb(fa_stb), .wdata(bus_wdata), .q(fsel_a));
   gpio_pinctl_bitreg #(.W(NPINS), .RST_VAL('0), .HAS_ALIAS(1'b0)) u_fsel_b (
      .clk(clk), .rst_n(rst_n), .stb(fb_stb), .wdata(bus_wdata), .q(fsel_b));

   gpio_pinctl_padmap #(.NPINS(NPINS)) u_padmap (
      .dout(dout), .dir(dir), .poff(poff), .fsel_a(fsel_a), .fsel_b(fsel_b),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
      .pad_pull_up(pad_pull_up), .pad_func(pad_func));
endmodule

// File: rtl/gpio_pinctl_chk.sv
module gpio_pinctl_chk
   import gpio_pinctl_pkg::*;
#(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [ADDR_W-1:0]       bus_addr,
   input logic                    bus_we,
   input logic [NPINS-1:0]        bus_wdata,
   input logic [NPINS-1:0]        bus_rdata,
   input logic [NPINS-1:0]        pad_out,
   input logic [NPINS-1:0]        pad_oe,
   input logic [NPINS-1:0]        pad_pull_en,
   input logic [NPINS-1:0]        pad_pull_up,
   input logic [FUNC_W*NPINS-1:0] pad_func
);
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(OFF_DOUT);
   localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(OFF_DOUT_SET);
   localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(OFF_DOUT_CLR);
   localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
   localparam logic [ADDR_W-1:0] A_RSET = ADDR_W'(OFF_DIR_SET);
   localparam logic [ADDR_W-1:0] A_RCLR = ADDR_W'(OFF_DIR_CLR);
   localparam logic [ADDR_W-1:0] A_FA   = ADDR_W'(OFF_FSEL_A);
   localparam logic [ADDR_W-1:0] A_FB   = ADDR_W'(OFF_FSEL_B);

   logic dwr, rwr, fwr;
   assign dwr = bus_we && (bus_addr == A_DOUT || bus_addr == A_DSET || bus_addr == A_DCLR);
   assign rwr = bus_we && (bus_addr == A_DIR  || bus_addr == A_RSET || bus_addr == A_RCLR);
   assign fwr = bus_we && (bus_addr == A_FA   || bus_addr == A_FB);

   // R2
   data_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DSET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

   // R2
   data_set_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DSET) |=>
         ((pad_out & ~$past(bus_wdata)) == ($past(pad_out) & ~$past(bus_wdata))));

   // R3
   data_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DCLR) |=> ((pad_out & $past(bus_wdata)) == '0));

   // R4
   dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rwr |=> $stable(pad_oe));

   // R5
   func_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fwr |=> $stable(pad_func));

   // R6
   pull_on_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_pull_en & pad_oe) == '0));

   // R7
   pull_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dwr |=> ($stable(pad_pull_up) && $stable(pad_out)));

   // R9
   unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr > A_FB) |-> (bus_rdata == '0));
endmodule

bind gpio_pinctl_bank gpio_pinctl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gpio_pinctl_bank.sv
module tb_gpio_pinctl_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
   logic [63:0] pad_func;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_dout = '0, m_dir = '0, m_poff = '0, m_fa = '0, m_fb = '0;

   always #5 clk = ~clk;

   gpio_pinctl_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
      .pad_pull_up(pad_pull_up), .pad_func(pad_func));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      #1;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic check_all(string req);
      logic [31:0] v;
      check({req, " pad_out"}, pad_out, m_dout);
      check({req, " pad_oe"}, pad_oe, m_dir);
      check({req, " R6 pull_en"}, pad_pull_en, ~m_poff & ~m_dir);
      check({req, " R7 pull_up"}, pad_pull_up, m_dout);
      rd(4'h1, v); check({req, " read data"}, v, m_dout);
      rd(4'h4, v); check({req, " read dir"}, v, m_dir);
      rd(4'h7, v); check({req, " read pull_off"}, v, m_poff);
      rd(4'h8, v); check({req, " R5 read fsel A"}, v, m_fa);
      rd(4'h9, v); check({req, " R5 read fsel B"}, v, m_fb);
      for (int i = 0; i < 32; i++)
         check({req, " R5 pad_func"}, {30'd0, pad_func[2*i +: 2]}, {30'd0, m_fb[i], m_fa[i]});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, p, q;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check_all("R1 reset");
      check("R1 pull_en all on", pad_pull_en, 32'hFFFF_FFFF);

      // R10 whole-word writes
      wr(4'h1, 32'hA5A5_3C3C); m_dout = 32'hA5A5_3C3C; check_all("R10 data word");
      wr(4'h4, 32'h0F0F_00FF); m_dir = 32'h0F0F_00FF; check_all("R10 dir word");

      // R2 R3 set/clear aliases on data, several patterns
      for (int k = 0; k < 8; k++) begin
         p = 32'h9E37_79B9 * (k + 1);
         q = {p[15:0], p[31:16]} ^ 32'h0000_FFFF;
         wr(4'h2, p); m_dout = m_dout | p;  check_all("R2 data set");
         wr(4'h3, q); m_dout = m_dout & ~q; check_all("R3 data clear");
      end
      // R2 R3 single-pin walk
      wr(4'h1, 32'h0); m_dout = '0;
      for (int i = 0; i < 32; i++) begin
         wr(4'h2, 32'h1 << i); m_dout |= 32'h1 << i;
         check("R2 single set", pad_out, m_dout);
      end
      for (int i = 0; i < 32; i += 3) begin
         wr(4'h3, 32'h1 << i); m_dout &= ~(32'h1 << i);
         check("R3 single clear", pad_out, m_dout);
      end

      // R4 direction aliases
      for (int k = 0; k < 6; k++) begin
         p = 32'h6A09_E667 * (k + 3);
         q = ~p ^ {p[7:0], p[31:8]};
         wr(4'h5, p); m_dir = m_dir | p;  check_all("R4 dir set");
         wr(4'h6, q); m_dir = m_dir & ~q; check_all("R4 dir clear");
      end

      // R5 function code sweep: pin i gets code (i+k)%4
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 32; i++) begin
            m_fa[i] = ((i + k) % 4) & 1;
            m_fb[i] = (((i + k) % 4) >> 1) & 1;
         end
         wr(4'h8, m_fa); wr(4'h9, m_fb);
         check_all("R5 function sweep");
      end

      // R6 R7 pull combinations
      wr(4'h4, 32'h0000_FFFF); m_dir = 32'h0000_FFFF;
      wr(4'h7, 32'h00FF_00FF); m_poff = 32'h00FF_00FF;
      wr(4'h1, 32'h0F0F_0F0F); m_dout = 32'h0F0F_0F0F;
      check_all("R6 R7 pull mix");
      // R7 corner: pin 3 driven high as output, then turned to input
      wr(4'h7, 32'h0); m_poff = '0;
      wr(4'h5, 32'h8); m_dir |= 32'h8;
      wr(4'h2, 32'h8); m_dout |= 32'h8;
      check("R6 pin3 output no pull", {31'd0, pad_pull_en[3]}, 32'd0);
      wr(4'h6, 32'h8); m_dir &= ~32'h8;
      check("R6 pin3 input pull on", {31'd0, pad_pull_en[3]}, 32'd1);
      check("R7 pin3 pull up", {31'd0, pad_pull_up[3]}, 32'd1);
      wr(4'h3, 32'h8); m_dout &= ~32'h8;
      check("R7 pin3 pull down", {31'd0, pad_pull_up[3]}, 32'd0);
      check_all("R7 corner");

      // R8 input synchronizer latency
      bus_addr = 4'h0;
      v = 32'h0;
      for (int k = 0; k < 5; k++) begin
         p = 32'hDEAD_BEEF ^ (32'h1357_9BDF * k);
         @(negedge clk); pad_in = p;
         @(negedge clk); #1; check("R8 after one edge", bus_rdata, v);
         @(negedge clk); #1; check("R8 after two edges", bus_rdata, p);
         v = p;
      end

      // R9 aliases and unmapped addresses read zero; unmapped writes ignored
      rd(4'h2, v); check("R9 read data set alias", v, 32'h0);
      rd(4'h3, v); check("R9 read data clear alias", v, 32'h0);
      rd(4'h5, v); check("R9 read dir set alias", v, 32'h0);
      rd(4'h6, v); check("R9 read dir clear alias", v, 32'h0);
      for (int a = 10; a < 16; a++) begin
         wr(a[3:0], 32'hFFFF_FFFF);
         rd(a[3:0], v); check("R9 unmapped read", v, 32'h0);
         check_all("R9 unmapped write ignored");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule